// File: doc/BRIEF.md
# Control Port Enable and Serial Format Selector

This block decides how a device that has a set of shared configuration pins is configured. After reset it runs in stand-alone mode. In that mode the shared pins are read as straps, and a start-up timer counts rising edges of the audio frame clock. Once `PWRUP_FRAMES` edges have been counted (1024 by default), the stand-alone start-up is complete. The frame clock is unrelated to the system clock, so it passes through a synchroniser and an edge detector before it is counted.

A serial write that sets the port-enable bit can arrive at any time after reset. When it does, the block stops the start-up timer, issues a one-cycle request to load the register defaults, and hands the shared pins to the serial control port. From then on the strap values stay frozen. The block also flags whether the enable came late, that is, after the stand-alone start-up had already finished.

While the port is enabled, the block watches the pin that doubles as chip-select and address strap. The first falling edge on that pin selects SPI format for good. Without such an edge, I2C format applies. The serial engines themselves sit outside this block; they consume the mode flags.

Top module: `ctlport_mode_sel`

## Requirements
- R1: While reset is asserted and right after it, every output is 0.
- R2: Each rising edge of `frame_clk_in` is counted two system-clock cycles after it is sampled. `pwrup_done` rises at the edge where the `PWRUP_FRAMES`-th edge is counted, provided the port is not enabled. It then stays 1 until reset.
- R3: A cycle with `en_wr_stb`=1 and `en_wr_bit`=1 while the port is inactive sets `ctl_active` at the next edge. `load_defaults` is 1 for exactly that one cycle. `ctl_active` stays 1 until reset.
- R4: Once the port is enabled before start-up completes, `pwrup_done` never rises. If the enable and the final frame count fall on the same edge, the enable wins and `pwrup_done` stays 0.
- R5: `late_enable` is set at the enable edge if and only if `pwrup_done` was already 1. The enable is accepted in both cases.
- R6: A strobe with `en_wr_bit`=0, or a repeated enable strobe while the port is already active, changes nothing and produces no `load_defaults` pulse.
- R7: While the port is inactive, `strap_val` follows `strap_pins` with a latency of three edges. From the enable edge on it is frozen.
- R8: A falling edge on `cs_addr_pin`, detected after synchronisation while `ctl_active` is 1, sets `spi_mode`, which stays 1 until reset. Falling edges detected while the port is inactive are ignored. `i2c_mode` is `ctl_active` and not `spi_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk_in | input | 1 | Audio frame clock, asynchronous |
| cs_addr_pin | input | 1 | Shared chip-select / address strap pin, asynchronous |
| strap_pins | input | STRAP_W | Shared configuration pins read as straps |
| en_wr_stb | input | 1 | Strobe: a serial write to the enable bit occurs |
| en_wr_bit | input | 1 | Value written to the enable bit |
| strap_val | output | STRAP_W | Synchronised strap values, frozen after enable |
| ctl_active | output | 1 | Serial control port owns the shared pins |
| spi_mode | output | 1 | SPI format selected |
| i2c_mode | output | 1 | I2C format in use |
| load_defaults | output | 1 | One-cycle request to reload register defaults |
| pwrup_done | output | 1 | Stand-alone start-up sequence completed |
| late_enable | output | 1 | Enable arrived after start-up completed |

## Verification
Two functions can fall in the same cycle: the enable write and the count of the final frame edge. The bench provokes this by driving the last frame-clock rise and placing the enable strobe exactly two cycles later, which is the edge where that rise is counted. It then checks that the port is active, that `pwrup_done` is still 0 and that `late_enable` is 0. A second coincidence, a chip-select falling edge detected before enable, is driven as well, and the bench expects the block to remain in I2C mode.

// File: rtl/ctlmode_pkg.sv
package ctlmode_pkg;

  typedef enum logic [1:0] {
    PM_STANDALONE = 2'd0,
    PM_I2C        = 2'd1,
    PM_SPI        = 2'd2
  } port_mode_e;

  // true when one more counted frame reaches the target
  function automatic logic count_reaches(input int unsigned cnt_now,
                                         input int unsigned target);
    return (cnt_now + 1) == target;
  endfunction

  // late flag captured at the enable edge
  function automatic logic late_on_enable(input logic fire, input logic done_now,
                                          input logic late_now);
    return fire ? done_now : late_now;
  endfunction

endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {WIDTH{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter bit   FALLING = 1'b0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic edge_hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_hit = prev_q & ~d;
    end else begin : g_rise
      assign edge_hit = ~prev_q & d;
    end
  endgenerate
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer
  import ctlmode_pkg::*;
#(
  parameter int FRAMES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic halt,
  output logic done
);
  localparam int CNT_W = $clog2(FRAMES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             count_en;
  logic             last_tick;

  assign count_en  = tick & ~halt & ~done;
  assign last_tick = count_en & count_reaches(32'(cnt_q), FRAMES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      if (count_en) cnt_q <= cnt_q + CNT_W'(1);
      if (last_tick) done <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !done) |=> !done); // R4
endmodule

// File: rtl/mode_latch.sv
module mode_latch
  import ctlmode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic cs_fall,
  input  logic done_in,
  output logic enable_fire,
  output logic active,
  output logic spi,
  output logic i2c,
  output logic ld_pulse,
  output logic late
);
  port_mode_e mode_q;
  logic       spi_hit;

  assign enable_fire = wr_stb & wr_bit & (mode_q == PM_STANDALONE);
  assign spi_hit     = cs_fall & (mode_q == PM_I2C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_STANDALONE;
      ld_pulse <= 1'b0;
      late     <= 1'b0;
    end else begin
      ld_pulse <= enable_fire;
      late     <= late_on_enable(enable_fire, done_in, late);
      if (enable_fire)  mode_q <= PM_I2C;
      else if (spi_hit) mode_q <= PM_SPI;
    end
  end

  assign active = (mode_q != PM_STANDALONE);
  assign spi    = (mode_q == PM_SPI);
  assign i2c    = (mode_q == PM_I2C);

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active); // R3
  AST_LD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pulse |=> !ld_pulse); // R3
  AST_LD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ld_pulse); // R3
  AST_LATE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> active); // R5
  AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spi |=> spi); // R8
  AST_NO_REPEAT_LD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_stb) |=> !ld_pulse); // R6
endmodule

// File: rtl/ctlport_mode_sel.sv
module ctlport_mode_sel
  import ctlmode_pkg::*;
#(
  parameter int PWRUP_FRAMES = 1024,
  parameter int STRAP_W      = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_clk_in,
  input  logic               cs_addr_pin,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               en_wr_stb,
  input  logic               en_wr_bit,
  output logic [STRAP_W-1:0] strap_val,
  output logic               ctl_active,
  output logic               spi_mode,
  output logic               i2c_mode,
  output logic               load_defaults,
  output logic               pwrup_done,
  output logic               late_enable
);
  logic               frame_sync;
  logic               frame_rise;
  logic               cs_sync;
  logic               cs_fall;
  logic [STRAP_W-1:0] strap_sync;
  logic               enable_fire;
  logic               timer_halt;

  sync_stage #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fsync (
    .clk(clk), .rst_n(rst_n), .d(frame_clk_in), .q(frame_sync));
  edge_det #(.FALLING(1'b0), .RST_VAL(1'b0)) u_frise (
    .clk(clk), .rst_n(rst_n), .d(frame_sync), .edge_hit(frame_rise));

  sync_stage #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csync (
    .clk(clk), .rst_n(rst_n), .d(cs_addr_pin), .q(cs_sync));
  edge_det #(.FALLING(1'b1), .RST_VAL(1'b1)) u_cfall (
    .clk(clk), .rst_n(rst_n), .d(cs_sync), .edge_hit(cs_fall));

  sync_stage #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ssync (
    .clk(clk), .rst_n(rst_n), .d(strap_pins), .q(strap_sync));

  assign timer_halt = ctl_active | enable_fire;

  pwrup_timer #(.FRAMES(PWRUP_FRAMES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(frame_rise), .halt(timer_halt),
    .done(pwrup_done));

  mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .wr_stb(en_wr_stb), .wr_bit(en_wr_bit),
    .cs_fall(cs_fall), .done_in(pwrup_done), .enable_fire(enable_fire),
    .active(ctl_active), .spi(spi_mode), .i2c(i2c_mode),
    .ld_pulse(load_defaults), .late(late_enable));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           strap_val <= '0;
    else if (!ctl_active) strap_val <= strap_sync;
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_active |=> $stable(strap_val)); // R7
  AST_SPI_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> (ctl_active && !i2c_mode)); // R8
  AST_LATE_MATCHES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_enable) |-> pwrup_done); // R5
endmodule

// File: tb/sim_ctlport_mode_sel.sv
`timescale 1ns/1ps
module sim_ctlport_mode_sel;
  localparam int N  = 1024;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk_in = 1'b0;
  logic cs_addr_pin = 1'b1;
  logic [SW-1:0] strap_pins = '0;
  logic en_wr_stb = 1'b0;
  logic en_wr_bit = 1'b0;
  logic [SW-1:0] strap_val;
  logic ctl_active, spi_mode, i2c_mode, load_defaults, pwrup_done, late_enable;

  always #2.5 clk = ~clk;

  ctlport_mode_sel #(.PWRUP_FRAMES(N), .STRAP_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_clk_in(frame_clk_in),
    .cs_addr_pin(cs_addr_pin), .strap_pins(strap_pins),
    .en_wr_stb(en_wr_stb), .en_wr_bit(en_wr_bit), .strap_val(strap_val),
    .ctl_active(ctl_active), .spi_mode(spi_mode), .i2c_mode(i2c_mode),
    .load_defaults(load_defaults), .pwrup_done(pwrup_done),
    .late_enable(late_enable));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural reference model
  bit fq[$];
  bit cq[$];
  logic [SW-1:0] sq[$];
  int m_cnt;
  bit m_done, m_act, m_spi, m_ld, m_late;
  logic [SW-1:0] m_strap;

  always @(posedge clk) begin
    if (!rst_n) begin
      fq = '{0, 0, 0};
      cq = '{1, 1, 1};
      sq = '{4'h0, 4'h0, 4'h0};
      m_cnt = 0; m_done = 0; m_act = 0; m_spi = 0; m_ld = 0; m_late = 0;
      m_strap = '0;
    end else begin
      bit rise, fall, wr, n_done, n_spi;
      logic [SW-1:0] n_strap;
      rise = fq[1] && !fq[0];
      fall = !cq[1] && cq[0];
      wr = en_wr_stb && en_wr_bit && !m_act;
      n_done = m_done;
      if (!m_act && !wr && !m_done && rise) begin
        m_cnt++;
        if (m_cnt == N) n_done = 1;
      end
      n_spi = m_spi || (m_act && fall);
      n_strap = m_act ? m_strap : sq[1];
      if (wr) m_late = m_done;
      m_ld = wr;
      m_act = m_act || wr;
      m_done = n_done;
      m_spi = n_spi;
      m_strap = n_strap;
      fq.push_back(frame_clk_in); void'(fq.pop_front());
      cq.push_back(cs_addr_pin);  void'(cq.pop_front());
      sq.push_back(strap_pins);   void'(sq.pop_front());
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2/R4 pwrup_done model", int'(pwrup_done), int'(m_done));
      check("R3 ctl_active model", int'(ctl_active), int'(m_act));
      check("R3/R6 load_defaults model", int'(load_defaults), int'(m_ld));
      check("R5 late_enable model", int'(late_enable), int'(m_late));
      check("R8 spi_mode model", int'(spi_mode), int'(m_spi));
      check("R8 i2c_mode model", int'(i2c_mode), int'(m_act && !m_spi));
      check("R7 strap_val model", int'(strap_val), int'(m_strap));
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      frame_clk_in = 1'b1; wait_n(3);
      frame_clk_in = 1'b0; wait_n(3);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_clk_in = 1'b0; cs_addr_pin = 1'b1; en_wr_stb = 1'b0; en_wr_bit = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic write_en(bit v);
    en_wr_stb = 1'b1; en_wr_bit = v;
    @(negedge clk);
    en_wr_stb = 1'b0; en_wr_bit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // scenario A: late enable, then SPI selection
    strap_pins = 4'hA;
    wait_n(3);
    check("R1 reset ctl_active", int'(ctl_active), 0);
    check("R1 reset pwrup_done", int'(pwrup_done), 0);
    check("R1 reset outputs", int'({spi_mode, i2c_mode, load_defaults, late_enable}), 0);
    check("R1 reset strap_val", int'(strap_val), 0);
    do_reset();
    wait_n(4);
    check("R7 strap follows", int'(strap_val), 'hA);
    frames(N + 4);
    check("R2 pwrup_done after count", int'(pwrup_done), 1);
    check("R2 still standalone", int'(ctl_active), 0);
    strap_pins = 4'h5; wait_n(4);
    check("R7 strap follows new", int'(strap_val), 5);
    write_en(1'b0);
    check("R6 zero bit ld", int'(load_defaults), 0);
    check("R6 zero bit active", int'(ctl_active), 0);
    write_en(1'b1);
    check("R3 ld pulse", int'(load_defaults), 1);
    check("R3 active", int'(ctl_active), 1);
    check("R5 late set", int'(late_enable), 1);
    @(negedge clk);
    check("R3 ld one cycle", int'(load_defaults), 0);
    strap_pins = 4'h3; wait_n(5);
    check("R7 strap frozen", int'(strap_val), 5);
    check("R8 i2c default", int'(i2c_mode), 1);
    cs_addr_pin = 1'b0; wait_n(4);
    check("R8 spi selected", int'(spi_mode), 1);
    check("R8 i2c off", int'(i2c_mode), 0);
    cs_addr_pin = 1'b1; wait_n(4);
    check("R8 spi sticky", int'(spi_mode), 1);
    write_en(1'b1);
    check("R6 repeat enable no ld", int'(load_defaults), 0);

    // scenario B: early enable halts start-up; pre-enable edge ignored
    do_reset();
    frames(100);
    cs_addr_pin = 1'b0; wait_n(4);
    cs_addr_pin = 1'b1; wait_n(4);
    check("R8 edge before enable ignored", int'(spi_mode), 0);
    write_en(1'b1);
    check("R5 early enable not late", int'(late_enable), 0);
    check("R3 early ld", int'(load_defaults), 1);
    frames(N);
    check("R4 halted never done", int'(pwrup_done), 0);
    check("R8 i2c without edge", int'(i2c_mode), 1);

    // scenario C: enable on the same edge as the final frame count
    do_reset();
    frames(N - 1);
    check("R2 not done one short", int'(pwrup_done), 0);
    frame_clk_in = 1'b1;
    wait_n(2);
    write_en(1'b1);
    frame_clk_in = 1'b0;
    wait_n(4);
    check("R4 coincident active", int'(ctl_active), 1);
    check("R4 coincident not done", int'(pwrup_done), 0);
    check("R5 coincident not late", int'(late_enable), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule